// File: doc/BRIEF.md
# Dual-Area Descriptor Stack Manager

This block keeps the per-message descriptor records of a command/response serial bus terminal that runs as either bus controller or remote terminal. Shared memory holds two descriptor regions, area A and area B. Each region has its own 64-entry stack pointer and its own message counter. The host chooses which area is current through a configuration register. A host change of area takes effect only between messages, so a message never moves from one area to the other while it is being recorded.

For each message the block writes a four-word entry into the current area. At message start it writes a start-flagged status word, the start time tag, the data block pointer and the command word. At message end it rewrites the time tag with the end time. It then posts the final status word with the end, error and bus flags. Writes go out one word at a time on a request/grant memory port, and the block waits while grant is low. In bus-controller mode each completed message lowers the current area's message count. A count of zero raises a frame-done flag and blocks further messages.

Top module: `desc_stack_mgr`

## Requirements
- R1: After reset `mem_req` is 0, `cur_area` is 0 (area A), `frame_done` is 0, and both stack pointers are at entry 0.
- R2: An accepted `msg_start` writes four words in this order: offset 0 = 16'h8000 (status, start flag bit 15), offset 1 = `time_now` at the start cycle, offset 2 = `msg_dptr`, offset 3 = `msg_cmd`. Each word lands at area base + 4*entry + offset.
- R3: An accepted `msg_end` writes offset 1 = `time_now` in the end cycle, and then offset 0 = the final status word. The final status word is always the last write of the message.
- R4: The final status word has bit 15 = 1 and bit 14 = 1 (end). Bit 13 equals `msg_bus_b` and bit 12 equals `msg_err`, both sampled with `msg_end`. Bits 11:0 are 0.
- R5: A word is accepted only in a cycle with `mem_req` and `mem_gnt` both high. While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr` and `mem_wdata` hold.
- R6: Host register write: address 0 is configuration, where bit 13 selects the area (0 = A at `BASE_A`, 1 = B at `BASE_B`) and bit 0 selects bus-controller mode. Address 1 loads the area A count and address 2 loads the area B count. Address 3 is ignored.
- R7: `cur_area` takes the requested area only in a cycle with no message in progress and no start accepted. A request made during a message waits until that message's final status word is written.
- R8: Each area's stack pointer advances by one entry (4 words) when its message completes. It wraps from entry 63 to entry 0 within its 256-word region, and it is independent of the other area's pointer.
- R9: In bus-controller mode a completed message decrements the current area's count if it is nonzero. `frame_done` is 1 exactly when bus-controller mode is set and the current area's count is 0. While `frame_done` is 1, `msg_start` is ignored.
- R10: `msg_start` is ignored while a message is in progress. `msg_end` is ignored when no message is in progress, and also after the first end of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 16 | Host register write data |
| msg_start | input | 1 | Message start event |
| msg_end | input | 1 | Message end event |
| msg_err | input | 1 | Error flag, valid with `msg_end` |
| msg_bus_b | input | 1 | Message used bus B, valid with `msg_end` |
| msg_cmd | input | 16 | Command word, valid with `msg_start` |
| msg_dptr | input | 16 | Data block pointer, valid with `msg_start` |
| time_now | input | 16 | Free-running time tag value |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write grant |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| cur_area | output | 1 | Current area, 0 = A, 1 = B |
| frame_done | output | 1 | Bus-controller frame finished |

## Verification
The assertions check four things on every cycle. The write port holds steady while it is stalled. The current area changes only when no message is in progress. Every write address stays inside the current area's region. The start and final status words have the right form. The remaining behaviour shows only in the bench's scenarios. These are the exact word order and contents of each entry, both time tags, and the pointer wrap after 64 messages. They also cover the area swap held off by a message in flight and the count reaching zero with a start then being refused. Early end events that arrive during the start writes, ignored duplicate events and random grant stalls are also driven.

// File: rtl/desc_stack_mgr.sv
module desc_stack_mgr #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int EB = 6,
  parameter logic [AW-1:0] BASE_A = 'h0000,
  parameter logic [AW-1:0] BASE_B = 'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          msg_start,
  input  logic          msg_end,
  input  logic          msg_err,
  input  logic          msg_bus_b,
  input  logic [DW-1:0] msg_cmd,
  input  logic [DW-1:0] msg_dptr,
  input  logic [DW-1:0] time_now,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cur_area,
  output logic          frame_done
);
  typedef enum logic [2:0] {IDLE, W_ST, W_TS, W_DP, W_CMD, ACT, E_TE, E_ST} st_t;

  st_t st;
  logic          area_req, bc_mode, end_seen, err_q, busb_q;
  logic [CW-1:0] cnt_a, cnt_b;
  logic [EB-1:0] sp_a, sp_b;
  logic [DW-1:0] tt_s, tt_e, dptr, cmd;
  logic [1:0]    widx;

  wire idle     = (st == IDLE);
  wire start_ok = idle && msg_start && !frame_done;
  wire end_ok   = !idle && msg_end && !end_seen;
  wire fire     = mem_req && mem_gnt;
  wire done     = (st == E_ST) && fire;
  wire [EB-1:0] sp = cur_area ? sp_b : sp_a;

  assign frame_done = bc_mode && (cur_area ? (cnt_b == '0) : (cnt_a == '0));
  assign mem_req    = !idle && (st != ACT);
  assign mem_addr   = (cur_area ? BASE_B : BASE_A) + AW'({sp, widx});

  always_comb begin
    widx      = 2'd0;
    mem_wdata = '0;
    case (st)
      W_ST:  begin widx = 2'd0; mem_wdata = 16'h8000; end
      W_TS:  begin widx = 2'd1; mem_wdata = tt_s; end
      W_DP:  begin widx = 2'd2; mem_wdata = dptr; end
      W_CMD: begin widx = 2'd3; mem_wdata = cmd; end
      E_TE:  begin widx = 2'd1; mem_wdata = tt_e; end
      E_ST:  begin widx = 2'd0; mem_wdata = {2'b11, busb_q, err_q, 12'h000}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      end_seen <= 1'b0;
    end else begin
      if (end_ok) end_seen <= 1'b1;
      case (st)
        IDLE:  if (start_ok) st <= W_ST;
        W_ST:  if (fire) st <= W_TS;
        W_TS:  if (fire) st <= W_DP;
        W_DP:  if (fire) st <= W_CMD;
        W_CMD: if (fire) st <= (end_seen || end_ok) ? E_TE : ACT;
        ACT:   if (end_ok) st <= E_TE;
        E_TE:  if (fire) st <= E_ST;
        E_ST:  if (fire) begin st <= IDLE; end_seen <= 1'b0; end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start_ok) begin
      tt_s <= time_now;
      dptr <= msg_dptr;
      cmd  <= msg_cmd;
    end
    if (end_ok) begin
      tt_e   <= time_now;
      err_q  <= msg_err;
      busb_q <= msg_bus_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_req <= 1'b0;
      cur_area <= 1'b0;
      bc_mode  <= 1'b0;
      cnt_a    <= '0;
      cnt_b    <= '0;
      sp_a     <= '0;
      sp_b     <= '0;
    end else begin
      if (idle && !start_ok) cur_area <= area_req;
      if (done) begin
        if (cur_area) sp_b <= sp_b + 1'b1;
        else          sp_a <= sp_a + 1'b1;
        if (bc_mode && !cur_area && cnt_a != '0) cnt_a <= cnt_a - 1'b1;
        if (bc_mode &&  cur_area && cnt_b != '0) cnt_b <= cnt_b - 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin area_req <= reg_wdata[13]; bc_mode <= reg_wdata[0]; end
          2'd1: cnt_a <= reg_wdata[CW-1:0];
          2'd2: cnt_b <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/desc_stack_mgr_chk.sv
module desc_stack_mgr_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int EB = 6,
  parameter logic [AW-1:0] BASE_A = 'h0000,
  parameter logic [AW-1:0] BASE_B = 'h0100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          cur_area,
  input logic          frame_done,
  input logic          msg_start,
  input logic          st_idle
);
  localparam logic [AW-1:0] RMASK = AW'((1 << (EB + 2)) - 1);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  assert_swap_between_msgs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_area) |-> $past(st_idle));

  assert_in_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ~RMASK) == (cur_area ? BASE_B : BASE_A)));

  assert_start_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_addr[1:0] == 2'd0 && !mem_wdata[14] |-> mem_wdata == 16'h8000);

  assert_final_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_addr[1:0] == 2'd0 && mem_wdata[14] |-> mem_wdata[15] && mem_wdata[11:0] == 12'h000);

  assert_no_start_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && frame_done && msg_start |=> !mem_req);
endmodule

bind desc_stack_mgr desc_stack_mgr_chk #(
  .AW(AW), .DW(DW), .EB(EB), .BASE_A(BASE_A), .BASE_B(BASE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_area(cur_area),
  .frame_done(frame_done), .msg_start(msg_start), .st_idle(idle)
);

// File: tb/desc_stack_mgr_bench.sv
module desc_stack_mgr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        msg_start = 1'b0, msg_end = 1'b0, msg_err = 1'b0, msg_bus_b = 1'b0;
  logic [15:0] msg_cmd = '0, msg_dptr = '0, time_now = '0;
  logic        mem_req, mem_gnt = 1'b1, cur_area, frame_done;
  logic [15:0] mem_addr, mem_wdata;

  always #4 clk = ~clk;

  desc_stack_mgr u_desc_stack_mgr (.*);

  typedef struct {logic [15:0] a; logic [15:0] d; bit last; string tag;} wr_t;
  wr_t q[$];
  bit m_busy, m_ended, m_area, m_req_area, m_bc;
  int m_cnt[2], m_sp[2];
  int checks = 0, fails = 0, cycles = 0;
  bit rnd_gnt = 0, finished = 0;

  function automatic logic [15:0] base_of(bit ar);
    return ar ? 16'h0100 : 16'h0000;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit m_fd();
    return m_bc && m_cnt[m_area] == 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_ended = 0; m_area = 0; m_req_area = 0; m_bc = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_sp[0] = 0; m_sp[1] = 0;
    end else begin
      bit st_ok, en_ok, was_busy, comp;
      logic [15:0] b;
      wr_t e;
      was_busy = m_busy;
      st_ok = !m_busy && msg_start && !m_fd();
      en_ok = m_busy && !m_ended && msg_end;
      comp = 0;
      b = base_of(m_area) + 16'(m_sp[m_area] * 4);
      if (q.size() != 0 && mem_gnt) begin
        e = q.pop_front();
        comp = e.last;
      end
      if (st_ok) begin
        q.push_back('{b + 16'd0, 16'h8000, 0, "R2"});
        q.push_back('{b + 16'd1, time_now, 0, "R2"});
        q.push_back('{b + 16'd2, msg_dptr, 0, "R2"});
        q.push_back('{b + 16'd3, msg_cmd, 0, "R2"});
        m_busy = 1;
      end
      if (en_ok) begin
        q.push_back('{b + 16'd1, time_now, 0, "R3"});
        q.push_back('{b, {2'b11, msg_bus_b, msg_err, 12'h000}, 1, "R4"});
        m_ended = 1;
      end
      if (comp) begin
        m_sp[m_area] = (m_sp[m_area] + 1) % 64;
        if (m_bc && m_cnt[m_area] != 0) m_cnt[m_area]--;
        m_busy = 0; m_ended = 0;
      end
      if (!was_busy && !st_ok) m_area = m_req_area;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin m_req_area = reg_wdata[13]; m_bc = reg_wdata[0]; end
          2'd1: m_cnt[0] = reg_wdata[7:0];
          2'd2: m_cnt[1] = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(mem_req == (q.size() != 0), "R5 req", {15'd0, mem_req}, {15'd0, q.size() != 0});
      if (q.size() != 0) begin
        chk(mem_addr == q[0].a, "R8 addr", mem_addr, q[0].a);
        chk(mem_wdata == q[0].d, q[0].tag, mem_wdata, q[0].d);
      end
      chk(cur_area == m_area, "R7 area", {15'd0, cur_area}, {15'd0, m_area});
      chk(frame_done == m_fd(), "R9 frame_done", {15'd0, frame_done}, {15'd0, m_fd()});
    end
    time_now <= time_now + 16'd3;
    mem_gnt <= rnd_gnt ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic host_wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_idle();
    while (m_busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(logic [15:0] c, logic [15:0] p, bit er, bit bb, int gap);
    @(negedge clk);
    msg_start = 1; msg_cmd = c; msg_dptr = p;
    @(negedge clk);
    msg_start = 0;
    repeat (gap) @(negedge clk);
    msg_end = 1; msg_err = er; msg_bus_b = bb;
    @(negedge clk);
    msg_end = 0; msg_err = 0; msg_bus_b = 0;
    wait_idle();
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R1 req", {15'd0, mem_req}, 16'd0);
    chk(cur_area == 0, "R1 area", {15'd0, cur_area}, 16'd0);
    chk(frame_done == 0, "R1 frame_done", {15'd0, frame_done}, 16'd0);
    chk(mem_addr == 16'h0000, "R1 pointer", mem_addr, 16'h0000);

    send(16'h1234, 16'h0400, 0, 0, 6);
    send(16'h2345, 16'h0500, 1, 0, 8);
    send(16'h3456, 16'h0600, 0, 1, 4);
    send(16'h4567, 16'h0700, 1, 1, 1);
    send(16'h5678, 16'h0800, 0, 0, 0);

    rnd_gnt = 1;
    for (int i = 0; i < 6; i++) send(16'(i * 7), 16'(i * 11), i[0], i[1], i % 5);

    // R10: end while idle is ignored
    @(negedge clk); msg_end = 1;
    @(negedge clk); msg_end = 0;
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R10 idle end", {15'd0, mem_req}, 16'd0);

    // R7: swap requested mid-message is held; R10: start during message ignored
    @(negedge clk); msg_start = 1; msg_cmd = 16'hAAAA; msg_dptr = 16'h0BBB;
    @(negedge clk); msg_start = 0;
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 16'h2000;
    @(negedge clk); reg_wr = 0;
    msg_start = 1; msg_cmd = 16'hDEAD;
    @(negedge clk); msg_start = 0;
    repeat (6) @(negedge clk);
    chk(cur_area == 0, "R7 held", {15'd0, cur_area}, 16'd0);
    msg_end = 1;
    @(negedge clk); msg_end = 0;
    msg_end = 1;
    @(negedge clk); msg_end = 0;
    wait_idle();
    chk(cur_area == 1, "R6 area B", {15'd0, cur_area}, 16'd1);

    send(16'hB001, 16'h0C00, 0, 1, 3);
    send(16'hB002, 16'h0C10, 1, 0, 2);
    host_wr(2'd3, 16'h2001);
    chk(frame_done == 0, "R6 addr3 ignored", {15'd0, frame_done}, 16'd0);

    // R8: wrap area A
    host_wr(2'd0, 16'h0000);
    rnd_gnt = 0;
    for (int i = 0; i < 60; i++) send(16'(16'h7000 + i), 16'(i), 0, 0, 0);
    chk(mem_req == 0, "R8 wrap done", {15'd0, mem_req}, 16'd0);
    rnd_gnt = 1;

    // R9: bus controller frame count
    host_wr(2'd1, 16'd2);
    host_wr(2'd0, 16'h0001);
    send(16'hC001, 16'h0D00, 0, 0, 2);
    send(16'hC002, 16'h0D10, 0, 0, 2);
    chk(frame_done == 1, "R9 count zero", {15'd0, frame_done}, 16'd1);
    @(negedge clk); msg_start = 1;
    @(negedge clk); msg_start = 0;
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R9 start blocked", {15'd0, mem_req}, 16'd0);
    host_wr(2'd1, 16'd1);
    chk(frame_done == 0, "R9 reload", {15'd0, frame_done}, 16'd0);
    send(16'hC003, 16'h0D20, 1, 1, 1);
    chk(frame_done == 1, "R9 count zero again", {15'd0, frame_done}, 16'd1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule